// File: doc/BRIEF.md
# Burst-Mode Serial Word Receiver

This block receives serial words over one or more data lanes in a data-driven burst format. It does not use periodic multi-slot framing. Each recognised frame sync edge starts exactly one word per lane. Capture begins after a programmable lead of zero, one or two bit periods. Any further bit periods after the word are discarded until the next edge.

The frame sync can come from a partner transmitter. The block can also generate the frame sync itself. In that case it issues a new one-bit-wide pulse only when the receiver is idle and the host has drained every enabled lane buffer.

The block runs on a single system clock. A one-cycle `bit_tick` strobe marks each falling bit clock edge, and all serial inputs are sampled on that strobe, MSB first. The word length ranges from 8 to 32 bits. Each lane holds its last word in a read buffer with a full flag and a sticky overrun flag. The host reads a buffer through a lane-indexed read port.

Top module: `rxb_burst_rx`

## Requirements
- R1: In external mode, a capture starts only on a tick where `fs_in` is 1 and `fs_in` was 0 on the previous tick, and only while the receiver is idle; holding `fs_in` high starts no further word.
- R2: `fs_delay` sets the lead from the recognised edge tick to the MSB. A value of 0 samples the MSB on the edge tick itself, 1 samples it on the next tick and 2 on the tick after that. A value of 3 behaves as 2.
- R3: Exactly `word_len` bits (8 to 32) are captured per lane, MSB first. The word is stored right-aligned in the lane buffer with the upper bits zero, and `rd_data` shows the buffer selected by `rd_lane`.
- R4: Ticks after the last bit of a word and before the next recognised edge capture nothing and change no buffer or flag.
- R5: A frame sync edge that arrives while a word is still being received is ignored, and the word in progress completes unchanged.
- R6: With `fs_int_en`=1, `fs_out` rises on a tick only when the receiver is idle and no enabled lane has its full flag set. It stays high for exactly one tick period, and that tick counts as the recognised edge.
- R7: A lane's full bit is set when a word completes on that lane. It is cleared by a host read (`rd_en` with `rd_lane` equal to that lane) unless a word completes in the same cycle.
- R8: A word that completes on a lane whose full bit is set, with no read of that lane in the same cycle, overwrites the buffer and sets that lane's sticky overrun bit. The overrun bit is cleared only by reset.
- R9: A lane whose `lane_en` bit is 0 keeps its buffer and its full and overrun bits unchanged.
- R10: After reset, `full`, `overrun`, `fs_out` and `rd_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe marking a falling bit clock edge |
| fs_int_en | input | 1 | 1: generate frame sync internally; 0: use fs_in |
| fs_in | input | 1 | External frame sync |
| fs_out | output | 1 | Internally generated frame sync |
| fs_delay | input | 2 | Lead from frame sync edge to MSB, in bit periods |
| word_len | input | WLEN_W | Bits per word, 8 to 32 |
| lane_en | input | LANES | Active lane mask |
| sdata | input | LANES | Serial data, one bit per lane |
| rd_en | input | 1 | Host read strobe |
| rd_lane | input | LANE_W | Lane selected for reading |
| rd_data | output | WORD_W | Buffer of the selected lane |
| full | output | LANES | Per-lane buffer-full flags |
| overrun | output | LANES | Per-lane sticky overrun flags |

## Verification
The assertions assume several things about the inputs. `bit_tick` is a single-cycle strobe. `word_len`, `fs_delay`, `lane_en` and `fs_int_en` change only while no word is in progress. `rd_lane` names an existing lane. The stimulus changes configuration only between words, after the trailing idle ticks. It spaces ticks four clocks apart and drives reads between ticks or on tick cycles. Under those conditions the frame sync width and gating properties and the full/overrun flag rules hold on every cycle, and the behavioural model in the bench predicts every output.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SHIFT = 2'd2
  } rxb_state_e;
  localparam logic [1:0] MAX_LEAD = 2'd2;
endpackage

// File: rtl/rxb_framer.sv
module rxb_framer
  import rxb_pkg::*;
#(
  parameter int WLEN_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              int_fs,
  input  logic              fs_in,
  input  logic [1:0]        lead_sel,
  input  logic [WLEN_W-1:0] word_len,
  input  logic              drain_wait,
  output logic              fs_out,
  output logic              cap,
  output logic              cap_first,
  output logic              word_done
);
  rxb_state_e        state_q, state_d;
  logic [WLEN_W-1:0] cnt_q, cnt_d;
  logic [1:0]        lead_q, lead_d;
  logic              fs_prev_q, fs_prev_d;
  logic              fs_out_q, fs_out_d;
  logic              ext_edge, gen_go, fs_edge;
  logic [1:0]        lead_eff;

  assign ext_edge = fs_in & ~fs_prev_q;
  assign gen_go   = int_fs & (state_q == ST_IDLE) & ~drain_wait & ~fs_out_q;
  assign fs_edge  = int_fs ? gen_go : ext_edge;
  assign lead_eff = (lead_sel > MAX_LEAD) ? MAX_LEAD : lead_sel;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    lead_d    = lead_q;
    fs_prev_d = fs_prev_q;
    fs_out_d  = fs_out_q;
    cap       = 1'b0;
    cap_first = 1'b0;
    word_done = 1'b0;
    if (bit_tick) begin
      fs_prev_d = fs_in;
      fs_out_d  = gen_go;
      unique case (state_q)
        ST_IDLE: begin
          if (fs_edge) begin
            if (lead_eff == 2'd0) begin
              cap       = 1'b1;
              cap_first = 1'b1;
              cnt_d     = WLEN_W'(1);
              state_d   = ST_SHIFT;
            end else begin
              lead_d  = lead_eff;
              state_d = ST_LEAD;
            end
          end
        end
        ST_LEAD: begin
          if (lead_q == 2'd1) begin
            cap       = 1'b1;
            cap_first = 1'b1;
            cnt_d     = WLEN_W'(1);
            state_d   = ST_SHIFT;
          end else begin
            lead_d = lead_q - 2'd1;
          end
        end
        ST_SHIFT: begin
          cap = 1'b1;
          if (cnt_q == word_len - WLEN_W'(1)) begin
            word_done = 1'b1;
            state_d   = ST_IDLE;
          end else begin
            cnt_d = cnt_q + WLEN_W'(1);
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      lead_q    <= '0;
      fs_prev_q <= 1'b0;
      fs_out_q  <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      lead_q    <= lead_d;
      fs_prev_q <= fs_prev_d;
      fs_out_q  <= fs_out_d;
    end
  end

  assign fs_out = fs_out_q;

  // R6: generated frame sync is one tick period wide
  assert_fs_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && fs_out_q) |=> !fs_out_q);

  // R6: generated frame sync only when idle and all enabled buffers drained
  assert_fs_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fs_out_q) |-> $past(int_fs && !drain_wait && state_q == ST_IDLE));

  // R5: a word finishes with the receiver going back to idle
  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> (state_q == ST_IDLE));
endmodule

// File: rtl/rxb_lane.sv
module rxb_lane #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              sd,
  input  logic              cap,
  input  logic              cap_first,
  input  logic              word_done,
  input  logic              rd_hit,
  output logic              full,
  output logic              overrun,
  output logic [WORD_W-1:0] data
);
  logic [WORD_W-1:0] sh_q, sh_d, sh_nx;
  logic [WORD_W-1:0] buf_q, buf_d;
  logic              full_q, full_d;
  logic              ovr_q, ovr_d;
  logic              commit;

  assign sh_nx  = cap_first ? {{(WORD_W-1){1'b0}}, sd} : {sh_q[WORD_W-2:0], sd};
  assign commit = word_done & en;

  always_comb begin
    sh_d   = sh_q;
    buf_d  = buf_q;
    full_d = full_q & ~rd_hit;
    ovr_d  = ovr_q;
    if (cap) sh_d = sh_nx;
    if (commit) begin
      buf_d  = sh_nx;
      full_d = 1'b1;
      ovr_d  = ovr_q | (full_q & ~rd_hit);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      buf_q  <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      buf_q  <= buf_d;
      full_q <= full_d;
      ovr_q  <= ovr_d;
    end
  end

  assign full    = full_q;
  assign overrun = ovr_q;
  assign data    = buf_q;

  // R8: an unread buffer that is overwritten flags overrun
  assert_overrun_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && full_q && !rd_hit) |=> ovr_q);

  // R7: a read without a new word empties the buffer
  assert_read_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && !commit) |=> !full_q);

  // R7: full rises only from a completed word
  assert_full_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_q) |-> $past(word_done && en));

  // R9: a disabled lane keeps its buffer
  assert_disabled_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(buf_q));
endmodule

// File: rtl/rxb_burst_rx.sv
module rxb_burst_rx #(
  parameter int LANES  = 2,
  parameter int WORD_W = 32,
  parameter int WLEN_W = $clog2(WORD_W) + 1,
  parameter int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              fs_int_en,
  input  logic              fs_in,
  output logic              fs_out,
  input  logic [1:0]        fs_delay,
  input  logic [WLEN_W-1:0] word_len,
  input  logic [LANES-1:0]  lane_en,
  input  logic [LANES-1:0]  sdata,
  input  logic              rd_en,
  input  logic [LANE_W-1:0] rd_lane,
  output logic [WORD_W-1:0] rd_data,
  output logic [LANES-1:0]  full,
  output logic [LANES-1:0]  overrun
);
  logic              rst_m_q, rst_s_q;
  logic              cap, cap_first, word_done;
  logic [WORD_W-1:0] lane_data [LANES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  rxb_framer #(.WLEN_W(WLEN_W)) u_framer (
    .clk        (clk),
    .rst_n      (rst_s_q),
    .bit_tick   (bit_tick),
    .int_fs     (fs_int_en),
    .fs_in      (fs_in),
    .lead_sel   (fs_delay),
    .word_len   (word_len),
    .drain_wait (|(full & lane_en)),
    .fs_out     (fs_out),
    .cap        (cap),
    .cap_first  (cap_first),
    .word_done  (word_done)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    rxb_lane #(.WORD_W(WORD_W)) u_lane (
      .clk       (clk),
      .rst_n     (rst_s_q),
      .en        (lane_en[i]),
      .sd        (sdata[i]),
      .cap       (cap),
      .cap_first (cap_first),
      .word_done (word_done),
      .rd_hit    (rd_en && (rd_lane == LANE_W'(i))),
      .full      (full[i]),
      .overrun   (overrun[i]),
      .data      (lane_data[i])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < LANES; i++) begin
      if (rd_lane == LANE_W'(i)) rd_data = lane_data[i];
    end
  end
endmodule

// File: tb/rxb_burst_rx_tb.sv
module rxb_burst_rx_tb;
  localparam int LANES = 2;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_tick = 1'b0, fs_int_en = 1'b0, fs_in = 1'b0, rd_en = 1'b0;
  logic [1:0]  fs_delay = 2'd0;
  logic [5:0]  word_len = 6'd8;
  logic [1:0]  lane_en = 2'b11, sdata = 2'b00, full, overrun;
  logic        rd_lane = 1'b0, fs_out;
  logic [31:0] rd_data;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  rxb_burst_rx u_dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .fs_int_en(fs_int_en),
    .fs_in(fs_in), .fs_out(fs_out), .fs_delay(fs_delay), .word_len(word_len),
    .lane_en(lane_en), .sdata(sdata), .rd_en(rd_en), .rd_lane(rd_lane),
    .rd_data(rd_data), .full(full), .overrun(overrun));

  // behavioural reference model
  bit          m_busy, m_prev, m_fs;
  int          m_pos, m_lead;
  logic [31:0] m_word [LANES];
  logic [31:0] m_buf  [LANES];
  logic [1:0]  m_full, m_ovr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_prev = 0; m_fs = 0; m_pos = 0; m_lead = 0;
      m_full = '0; m_ovr = '0;
      for (int l = 0; l < LANES; l++) begin m_word[l] = '0; m_buf[l] = '0; end
    end else begin
      bit commit, edge_seen;
      commit = 0;
      if (bit_tick) begin
        if (fs_int_en) edge_seen = !m_busy && ((m_full & lane_en) == 0);
        else           edge_seen = fs_in && !m_prev;
        m_fs   = fs_int_en && edge_seen;
        m_prev = fs_in;
        if (!m_busy && edge_seen) begin
          m_busy = 1; m_pos = 0; m_lead = (fs_delay > 2) ? 2 : int'(fs_delay);
          for (int l = 0; l < LANES; l++) m_word[l] = '0;
        end
        if (m_busy) begin
          if (m_pos >= m_lead) begin
            for (int l = 0; l < LANES; l++) m_word[l] = {m_word[l][30:0], sdata[l]};
            if (m_pos - m_lead == int'(word_len) - 1) begin commit = 1; m_busy = 0; end
          end
          m_pos++;
        end
      end
      for (int l = 0; l < LANES; l++) begin
        bit hit;
        hit = rd_en && (int'(rd_lane) == l);
        if (commit && lane_en[l]) begin
          if (m_full[l] && !hit) m_ovr[l] = 1'b1;
          m_buf[l] = m_word[l]; m_full[l] = 1'b1;
        end else if (hit) m_full[l] = 1'b0;
      end
    end
  end

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      check("R6 fs_out", 32'(fs_out), 32'(m_fs));
      check("R7 full", 32'(full), 32'(m_full));
      check("R8 overrun", 32'(overrun), 32'(m_ovr));
      check("R3 rd_data", rd_data, m_buf[rd_lane]);
    end
  end

  task automatic tstep(input logic fs, input logic [1:0] d);
    @(negedge clk); fs_in = fs; sdata = d; bit_tick = 1'b1;
    @(negedge clk); bit_tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic host_read(input logic l, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; rd_lane = l;
    #1 d = rd_data;
    @(negedge clk); rd_en = 1'b0;
  endtask

  // mode 0: single fs pulse; 1: extra fs pulse mid-word; 2: fs held high
  task automatic send_ext(input int dly, input int wl, input logic [31:0] w0,
                          input logic [31:0] w1, input int mode, input int tail);
    int lead;
    lead = (dly > 2) ? 2 : dly;
    fs_delay = 2'(dly); word_len = 6'(wl);
    for (int p = 0; p < lead + wl; p++) begin
      logic fs;
      logic [1:0] d;
      fs = (p == 0) || (mode == 1 && p == 4) || (mode == 2);
      if (p >= lead) d = {w1[wl-1-(p-lead)], w0[wl-1-(p-lead)]};
      else d = 2'b11;
      tstep(fs, d);
    end
    for (int t = 0; t < tail; t++) tstep(mode == 2, 2'(t + 1));
    if (mode == 2) tstep(1'b0, 2'b00);
  endtask

  task automatic drain;
    logic [31:0] d;
    host_read(1'b0, d);
    host_read(1'b1, d);
  endtask

  initial begin
    logic [31:0] d;
    int pulses;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 reset full", 32'(full), 0);
    check("R10 reset overrun", 32'(overrun), 0);
    check("R10 reset fs_out", 32'(fs_out), 0);
    check("R10 reset rd_data", rd_data, 0);

    send_ext(0, 8, 32'hA5, 32'h3C, 0, 3);
    check("R1 full after edge", 32'(full), 32'h3);
    host_read(1'b0, d); check("R2 delay0 lane0", d, 32'hA5);
    host_read(1'b1, d); check("R2 delay0 lane1", d, 32'h3C);

    send_ext(1, 16, 32'hBEEF, 32'h1234, 0, 2);
    host_read(1'b0, d); check("R2 delay1 lane0", d, 32'hBEEF);
    host_read(1'b1, d); check("R3 16-bit lane1", d, 32'h1234);

    send_ext(2, 32, 32'hDEADBEEF, 32'h80000001, 0, 2);
    host_read(1'b0, d); check("R3 32-bit lane0", d, 32'hDEADBEEF);
    host_read(1'b1, d); check("R2 delay2 lane1", d, 32'h80000001);

    send_ext(3, 12, 32'hABC, 32'h5A5, 0, 2);
    host_read(1'b0, d); check("R2 delay3 acts as 2", d, 32'hABC);
    host_read(1'b1, d); check("R3 12-bit upper zero", d, 32'h5A5);

    send_ext(0, 8, 32'h96, 32'h69, 2, 4);
    check("R1 held fs one word", 32'(full), 32'h3);
    drain;
    for (int t = 0; t < 5; t++) tstep(1'b0, 2'b11);
    check("R4 idle ticks no capture", 32'(full), 0);
    host_read(1'b0, d); check("R4 buffer kept", d, 32'h96);

    send_ext(1, 10, 32'h2F1, 32'h10E, 1, 2);
    host_read(1'b0, d); check("R5 mid-word edge ignored", d, 32'h2F1);
    host_read(1'b1, d); check("R5 mid-word edge lane1", d, 32'h10E);
    check("R5 single word", 32'(full), 0);

    send_ext(0, 8, 32'h11, 32'h22, 0, 1);
    send_ext(0, 8, 32'h33, 32'h44, 0, 1);
    check("R8 overrun set", 32'(overrun), 32'h3);
    host_read(1'b1, d); check("R8 overwritten", d, 32'h44);
    host_read(1'b0, d);
    check("R8 overrun sticky", 32'(overrun), 32'h3);

    lane_en = 2'b01;
    send_ext(0, 8, 32'h7E, 32'hFF, 0, 1);
    check("R9 disabled lane full", 32'(full), 32'h1);
    host_read(1'b1, d); check("R9 disabled lane buffer", d, 32'h44);
    host_read(1'b0, d); check("R9 enabled lane", d, 32'h7E);
    lane_en = 2'b11;

    fs_int_en = 1'b1; fs_delay = 2'd0; word_len = 6'd8;
    pulses = 0;
    for (int t = 0; t < 40; t++) begin
      tstep(1'b0, 2'(t ^ (t >> 2)));
      if (fs_out) pulses++;
    end
    check("R6 one pulse until drained", 32'(pulses), 1);
    drain;
    pulses = 0;
    for (int t = 0; t < 40; t++) begin
      tstep(1'b0, 2'(t * 3));
      if (fs_out) pulses++;
    end
    check("R6 pulse after drain", 32'(pulses), 1);
    fs_int_en = 1'b0;
    drain;
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule